// File: doc/BRIEF.md
# Multi-Source Chip Reset Sequencer

This block gathers every condition that may restart the chip and turns them into a single full reset output and a partial reset output. The triggers are: a supply-good flag and an oscillator-stable flag, an external reset pin that must stay high long enough, an EEPROM checksum error flag, a write strobe that sets a self-clearing software reset bit, any change into or out of a hardware low-power state, and leaving software suspend. Every full reset lasts a fixed minimum number of clocks after its last trigger, and it is released on a clock edge.

While software suspend is active, the partial reset output stays asserted and the full reset output does not. The partial reset goes to all logic except the two registers that must survive suspend: the I/O base address register and the self-control register. A sticky cause field records the origin of the most recent reset. It stays readable once the reset has ended. Apart from the external pin, all inputs are synchronous to `clk`. The pin passes through its own synchronizer.

Top module: `rstctl_top`

## Requirements
- R1: The external pin starts a full reset only after it has been high, as seen past the `SYNC_STAGES`-flop synchronizer, for `PIN_MIN_CYCLES` consecutive clocks (default 40, which is 400 ns at 100 MHz). A pulse that is one clock shorter leaves `chip_rst` low.
- R2: While `vdd_ok` or `osc_ok` is low, `chip_rst` is asserted from the next clock on. It is released only `HOLD_CYCLES` clocks after both flags are high again.
- R3: `chip_rst` stays high for exactly `HOLD_CYCLES` clocks after the last clock on which any full-reset trigger was present, and then falls on a clock edge.
- R4: A one-clock high on `eep_cksum_err` causes a full reset.
- R5: A `sw_rst_set` strobe sets `sw_rst_bit` and starts a full reset. The bit reads 1 until the edge on which `chip_rst` falls, and it clears on that same edge.
- R6: Both a rising and a falling change of `hw_lowpwr` start a full reset. Staying in the low-power state does not hold the reset.
- R7: Entering software suspend (`sw_susp` rising) asserts `part_rst` from the next clock for as long as suspend lasts. It does not assert `chip_rst`.
- R8: Leaving software suspend (`sw_susp` falling) starts a full reset.
- R9: `part_rst` is high on every clock on which `chip_rst` is high.
- R10: `rst_cause` holds the cause of the latest trigger and is kept after release. The codes are: 1 supply/oscillator, 2 pin, 3 EEPROM, 4 hardware low-power change, 5 suspend exit, 6 software bit, 7 suspend entry. When triggers coincide, the winner follows the order 1, 2, 3, 4, 5, 6, 7, with 1 the strongest.
- R11: While `rst` is asserted, and for `HOLD_CYCLES` clocks after it ends, `chip_rst` is high and `rst_cause` reads 1. `sw_rst_bit` reads 0 at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block itself |
| ext_rst_pin | input | 1 | External reset pin, asynchronous |
| vdd_ok | input | 1 | Supply above its threshold |
| osc_ok | input | 1 | Oscillator stable |
| eep_cksum_err | input | 1 | EEPROM checksum error flag |
| sw_rst_set | input | 1 | Write strobe that sets the software reset bit |
| hw_lowpwr | input | 1 | Hardware standby/suspend state |
| sw_susp | input | 1 | Software suspend state |
| chip_rst | output | 1 | Full chip reset |
| part_rst | output | 1 | Reset for all logic except the preserved registers |
| sw_rst_bit | output | 1 | Readable value of the software reset bit |
| rst_cause | output | 3 | Sticky code of the most recent reset cause |

## Verification
The external pin is driven with one pulse that is a single clock too short and one that is exactly long enough. The outcome shows whether the width qualifier counts correctly at its boundary. The supply and the oscillator flag are each dropped separately, to confirm that either one alone holds the reset and that the hold time restarts from the last low cycle. The hardware low-power state is entered, held past the hold time and left again; this separates edge-triggered behaviour from level-triggered behaviour. Software suspend entry and exit show that the partial reset follows suspend without the full reset, and simultaneous EEPROM and software triggers expose the cause priority.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE       = 3'd0,
        CAUSE_SUPPLY     = 3'd1,
        CAUSE_PIN        = 3'd2,
        CAUSE_EEPROM     = 3'd3,
        CAUSE_HWLP       = 3'd4,
        CAUSE_SUSP_EXIT  = 3'd5,
        CAUSE_SWBIT      = 3'd6,
        CAUSE_SUSP_ENTRY = 3'd7
    } cause_e;

    // One flag per trigger, strongest first.
    typedef struct packed {
        logic supply;
        logic pin;
        logic eeprom;
        logic hwlp;
        logic susp_exit;
        logic swbit;
        logic susp_entry;
    } req_t;

    function automatic logic wants_full(req_t r);
        return r.supply | r.pin | r.eeprom | r.hwlp | r.susp_exit | r.swbit;
    endfunction

    function automatic cause_e pick_cause(req_t r);
        cause_e c;
        if (r.supply)         c = CAUSE_SUPPLY;
        else if (r.pin)       c = CAUSE_PIN;
        else if (r.eeprom)    c = CAUSE_EEPROM;
        else if (r.hwlp)      c = CAUSE_HWLP;
        else if (r.susp_exit) c = CAUSE_SUSP_EXIT;
        else if (r.swbit)     c = CAUSE_SWBIT;
        else if (r.susp_entry) c = CAUSE_SUSP_ENTRY;
        else                  c = CAUSE_NONE;
        return c;
    endfunction

endpackage

// File: rtl/rstctl_pinqual.sv
module rstctl_pinqual #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_CYCLES  = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic qualified
);
    localparam int CW = $clog2(MIN_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    logic [CW-1:0]          run_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= pin_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
            end
        end
    endgenerate

    assign pin_s = sync_q[SYNC_STAGES-1];

    // Count consecutive synchronized-high cycles, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (rst || !pin_s)   run_q <= '0;
        else if (run_q != LAST) run_q <= run_q + 1'b1;
    end

    assign qualified = pin_s && (run_q == LAST);

endmodule

// File: rtl/rstctl_modewatch.sv
module rstctl_modewatch (
    input  logic clk,
    input  logic rst,
    input  logic hw_lowpwr,
    input  logic sw_susp,
    output logic hw_change,
    output logic susp_enter,
    output logic susp_leave,
    output logic in_susp
);
    logic hw_q;
    logic susp_q;

    // Track the current levels during reset so no edge is reported on release.
    always_ff @(posedge clk) begin
        hw_q   <= hw_lowpwr;
        susp_q <= sw_susp;
    end

    assign hw_change  = !rst && (hw_lowpwr != hw_q);
    assign susp_enter = !rst && sw_susp && !susp_q;
    assign susp_leave = !rst && !sw_susp && susp_q;
    assign in_susp    = susp_q;

endmodule

// File: rtl/rstctl_stretch.sv
module rstctl_stretch #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    output logic active,
    output logic final_cycle
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLD_CYCLES);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || trigger)    left_q <= LOAD;
        else if (left_q != '0) left_q <= left_q - 1'b1;
    end

    assign active      = (left_q != '0);
    assign final_cycle = (left_q == CW'(1));

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int PIN_MIN_CYCLES = 40,
    parameter int HOLD_CYCLES    = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_rst_pin,
    input  logic       vdd_ok,
    input  logic       osc_ok,
    input  logic       eep_cksum_err,
    input  logic       sw_rst_set,
    input  logic       hw_lowpwr,
    input  logic       sw_susp,
    output logic       chip_rst,
    output logic       part_rst,
    output logic       sw_rst_bit,
    output logic [2:0] rst_cause
);
    req_t   req;
    logic   pin_ok;
    logic   hw_change, susp_enter, susp_leave, in_susp;
    logic   full_trig;
    logic   stretch_active, stretch_last;
    logic   swbit_q;
    cause_e cause_q;

    rstctl_pinqual #(
        .SYNC_STAGES (SYNC_STAGES),
        .MIN_CYCLES  (PIN_MIN_CYCLES)
    ) u_pin (
        .clk       (clk),
        .rst       (rst),
        .pin_async (ext_rst_pin),
        .qualified (pin_ok)
    );

    rstctl_modewatch u_mode (
        .clk        (clk),
        .rst        (rst),
        .hw_lowpwr  (hw_lowpwr),
        .sw_susp    (sw_susp),
        .hw_change  (hw_change),
        .susp_enter (susp_enter),
        .susp_leave (susp_leave),
        .in_susp    (in_susp)
    );

    always_comb begin
        req.supply     = !(vdd_ok && osc_ok);
        req.pin        = pin_ok;
        req.eeprom     = eep_cksum_err;
        req.hwlp       = hw_change;
        req.susp_exit  = susp_leave;
        req.swbit      = sw_rst_set;
        req.susp_entry = susp_enter;
    end

    assign full_trig = !rst && wants_full(req);

    rstctl_stretch #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk         (clk),
        .rst         (rst),
        .trigger     (full_trig),
        .active      (stretch_active),
        .final_cycle (stretch_last)
    );

    // Software reset bit: set by strobe, cleared on the edge the reset ends.
    always_ff @(posedge clk) begin
        if (rst)                             swbit_q <= 1'b0;
        else if (sw_rst_set)                 swbit_q <= 1'b1;
        else if (stretch_last && !full_trig) swbit_q <= 1'b0;
    end

    // Sticky cause: updated on any trigger, including suspend entry.
    always_ff @(posedge clk) begin
        if (rst)                                cause_q <= CAUSE_SUPPLY;
        else if (full_trig || req.susp_entry)   cause_q <= pick_cause(req);
    end

    assign chip_rst   = stretch_active;
    assign part_rst   = stretch_active || in_susp;
    assign sw_rst_bit = swbit_q;
    assign rst_cause  = cause_q;

endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk #(
    parameter int HOLD_CYCLES = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       vdd_ok,
    input logic       osc_ok,
    input logic       eep_cksum_err,
    input logic       hw_lowpwr,
    input logic       sw_susp,
    input logic       chip_rst,
    input logic       part_rst,
    input logic       sw_rst_bit
);
    int unsigned high_run;

    always_ff @(posedge clk) begin
        if (rst || !chip_rst) high_run <= 0;
        else                  high_run <= high_run + 1;
    end

    AST_SUPPLY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(vdd_ok && osc_ok) |=> chip_rst); // R2

    AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(chip_rst) |-> (high_run >= HOLD_CYCLES)); // R3

    AST_EEPROM_TRIG: assert property (@(posedge clk) disable iff (rst)
        eep_cksum_err |=> chip_rst); // R4

    AST_SWBIT_SELFCLR: assert property (@(posedge clk) disable iff (rst)
        $fell(chip_rst) |-> !sw_rst_bit); // R5

    AST_HW_EDGE: assert property (@(posedge clk) disable iff (rst)
        (hw_lowpwr != $past(hw_lowpwr)) |=> chip_rst); // R6

    AST_SUSP_LEAVE: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_susp) |=> chip_rst); // R8

    AST_PART_COVERS: assert property (@(posedge clk) disable iff (rst)
        chip_rst |-> part_rst); // R9

endmodule

bind rstctl_top rstctl_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .vdd_ok        (vdd_ok),
    .osc_ok        (osc_ok),
    .eep_cksum_err (eep_cksum_err),
    .hw_lowpwr     (hw_lowpwr),
    .sw_susp       (sw_susp),
    .chip_rst      (chip_rst),
    .part_rst      (part_rst),
    .sw_rst_bit    (sw_rst_bit)
);

// File: tb/rstctl_top_test.sv
module rstctl_top_test;
    localparam int SYNC = 2;
    localparam int PMIN = 40;
    localparam int HOLD = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin = 1'b0, vdd = 1'b1, osc = 1'b1, eep = 1'b0;
    logic swset = 1'b0, hw = 1'b0, ss = 1'b0;
    logic chip_rst, part_rst, sw_rst_bit;
    logic [2:0] rst_cause;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rstctl_top #(.SYNC_STAGES(SYNC), .PIN_MIN_CYCLES(PMIN), .HOLD_CYCLES(HOLD)) uut (
        .clk(clk), .rst(rst), .ext_rst_pin(pin), .vdd_ok(vdd), .osc_ok(osc),
        .eep_cksum_err(eep), .sw_rst_set(swset), .hw_lowpwr(hw), .sw_susp(ss),
        .chip_rst(chip_rst), .part_rst(part_rst), .sw_rst_bit(sw_rst_bit),
        .rst_cause(rst_cause)
    );

    // Behavioural reference model, advanced on each rising edge.
    int m_left = HOLD, m_run = 0, m_cause = 1;
    int pin_hist[$];
    bit m_bit = 0, m_hw = 0, m_ss = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_left = HOLD; m_cause = 1; m_run = 0; m_bit = 0;
            m_hw = hw; m_ss = ss;
            pin_hist = {};
            for (int i = 0; i < SYNC; i++) pin_hist.push_back(0);
        end else begin
            bit seen, pin_req, sup, hwc, lv, en, full;
            seen = pin_hist[0];
            pin_req = seen && (m_run >= PMIN - 1);
            m_run = seen ? m_run + 1 : 0;
            void'(pin_hist.pop_front());
            pin_hist.push_back(pin);
            sup = !(vdd && osc);
            hwc = (hw != m_hw);
            lv  = m_ss && !ss;
            en  = !m_ss && ss;
            full = sup || pin_req || eep || hwc || lv || swset;
            if (sup) m_cause = 1;
            else if (pin_req) m_cause = 2;
            else if (eep) m_cause = 3;
            else if (hwc) m_cause = 4;
            else if (lv) m_cause = 5;
            else if (swset) m_cause = 6;
            else if (en) m_cause = 7;
            if (swset) m_bit = 1;
            else if (!full && m_left == 1) m_bit = 0;
            if (full) m_left = HOLD;
            else if (m_left > 0) m_left--;
            m_hw = hw; m_ss = ss;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Clock-by-clock comparison against the model.
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R3 chip_rst", chip_rst, (m_left > 0));
            check("R9 part_rst", part_rst, (m_left > 0) || m_ss);
            check("R5 sw_rst_bit", sw_rst_bit, m_bit);
            check("R10 rst_cause", rst_cause, m_cause);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        check("R11 chip_rst after reset", chip_rst, 1);
        check("R11 cause after reset", rst_cause, 1);
        check("R11 sw bit after reset", sw_rst_bit, 0);
        cyc(HOLD + 4);
        check("R11 released", chip_rst, 0);

        // R1: one clock too short
        pin = 1'b1; cyc(PMIN - 1); pin = 1'b0;
        cyc(SYNC + 6);
        check("R1 short pulse ignored", chip_rst, 0);
        check("R1 short pulse cause", rst_cause, 1);
        // R1: exactly long enough
        pin = 1'b1; cyc(PMIN); pin = 1'b0;
        cyc(SYNC + 1);
        check("R1 qualified pulse", chip_rst, 1);
        check("R1 cause pin", rst_cause, 2);
        cyc(HOLD + 4);

        // R2: supply drop, then oscillator drop
        vdd = 1'b0; cyc(5);
        check("R2 held by supply", chip_rst, 1);
        vdd = 1'b1; cyc(HOLD - 1);
        check("R2 not yet released", chip_rst, 1);
        cyc(2);
        check("R2 released", chip_rst, 0);
        osc = 1'b0; cyc(2);
        check("R2 held by osc", chip_rst, 1);
        check("R2 cause", rst_cause, 1);
        osc = 1'b1; cyc(HOLD + 3);

        // R4: EEPROM error pulse
        eep = 1'b1; cyc(1); eep = 1'b0;
        check("R4 eeprom reset", chip_rst, 1);
        check("R4 cause", rst_cause, 3);
        cyc(HOLD + 3);

        // R5: software bit
        swset = 1'b1; cyc(1); swset = 1'b0;
        check("R5 bit set", sw_rst_bit, 1);
        check("R5 reset on", chip_rst, 1);
        cyc(HOLD + 2);
        check("R5 bit cleared", sw_rst_bit, 0);
        check("R5 cause", rst_cause, 6);

        // R6: hardware low-power entry and exit
        hw = 1'b1; cyc(1);
        check("R6 entry reset", chip_rst, 1);
        check("R6 cause", rst_cause, 4);
        cyc(HOLD + 5);
        check("R6 level does not hold", chip_rst, 0);
        hw = 1'b0; cyc(1);
        check("R6 exit reset", chip_rst, 1);
        cyc(HOLD + 3);

        // R7 / R8: software suspend
        ss = 1'b1; cyc(2);
        check("R7 partial on", part_rst, 1);
        check("R7 full off", chip_rst, 0);
        check("R7 cause", rst_cause, 7);
        cyc(HOLD + 3);
        check("R7 partial held", part_rst, 1);
        ss = 1'b0; cyc(1);
        check("R8 exit reset", chip_rst, 1);
        check("R8 cause", rst_cause, 5);
        cyc(HOLD + 3);

        // R10: priority and stickiness
        eep = 1'b1; swset = 1'b1; cyc(1); eep = 1'b0; swset = 1'b0;
        check("R10 priority", rst_cause, 3);
        cyc(HOLD + 5);
        check("R10 sticky after release", rst_cause, 3);

        finish_run();
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

endmodule